// File: doc/BRIEF.md
# Slave Clock Ratio Detector

This block sits beside an audio converter that receives its sample clocks from outside. From three incoming clocks it works out how the converter must be set up. The clocks are a master clock, a frame (left/right) clock and a bit clock. The block finds the speed band of the frame rate and the master-clock-to-frame ratio. From those it derives whether the master clock has to be halved internally.

Some ratios are legal in both speed bands, 256x being the main case. A count of master clocks per frame cannot tell the bands apart for such a ratio. The block therefore also times each frame period against a free-running reference clock of known frequency. Master clocks and bit clocks are counted in the master-clock domain. The frame period is counted in the reference domain. Each finished master-domain measurement is handed across with a toggle handshake. All decisions and outputs live in the reference domain.

A decision is accepted only when three consecutive frames give the same legal result. The lock flag then rises. Any differing or illegal frame drops the lock. The decision outputs keep the last accepted setting until a new one is locked.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is asserted and right after it, `locked`, `clocksBad`, `speedDouble`, `mclkDiv2` and `ratioCode` are all 0.
- R2: A frame rate from 4 kHz to 54 kHz (measured period from REF_HZ/54000 to REF_HZ/4000 reference cycles) is single speed (`speedDouble`=0). Legal ratios in this band give these outputs: 256x → `ratioCode` 3 with `mclkDiv2`=0; 384x → code 4 with `mclkDiv2`=0; 512x → code 5 with `mclkDiv2`=1; 768x → code 6 with `mclkDiv2`=1.
- R3: A frame rate from 86 kHz to 108 kHz is double speed (`speedDouble`=1). Legal ratios in this band give these outputs: 128x → code 1 with `mclkDiv2`=0; 192x → code 2 with `mclkDiv2`=0; 256x → code 3 with `mclkDiv2`=1; 384x → code 4 with `mclkDiv2`=1.
- R4: A 256x or 384x ratio is assigned to a band by the measured frame period alone. A frame rate outside both bands (for example 70 kHz) makes the frame invalid.
- R5: A master-clock count per frame matches a listed ratio within ±2 clocks (258 counts as 256x). A count further from every listed ratio, or a ratio not legal in the measured band, makes the frame invalid.
- R6: With ratio codes 1, 3 or 5, exactly 64 bit-clock rising edges per frame are required. With codes 2, 4 or 6, either 48 or 64 are accepted. Any other count makes the frame invalid.
- R7: `locked` rises only when three consecutive evaluated frames give the same valid result. The first frame clock edge after reset only starts the measurement.
- R8: A frame whose result is invalid, or differs from the previous one, clears `locked` at its evaluation. `speedDouble`, `mclkDiv2` and `ratioCode` keep their last locked values and change only when `locked` is asserted again.
- R9: `clocksBad` shows whether the latest evaluation was invalid. It is set by an invalid frame or a timeout and cleared by a valid frame. It is never 1 together with `locked`.
- R10: After a frame clock edge has been seen, more than REF_HZ/4000 reference cycles with no frame clock rising edge clear `locked` and set `clocksBad`.
- R11: The frame period is taken from rising edge to rising edge, so any frame clock duty cycle from 40 % to 60 % gives the same decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Incoming master clock |
| refClk | input | 1 | Free-running reference clock of REF_HZ |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| lrck | input | 1 | Incoming frame clock; a frame starts at its rising edge |
| sclk | input | 1 | Incoming bit clock |
| speedDouble | output | 1 | 1 = double-speed band, 0 = single-speed band (last locked) |
| mclkDiv2 | output | 1 | 1 = halve the master clock internally (last locked) |
| ratioCode | output | 3 | 0 none, 1=128x, 2=192x, 3=256x, 4=384x, 5=512x, 6=768x (last locked) |
| locked | output | 1 | Three consecutive identical valid frames seen |
| clocksBad | output | 1 | Latest evaluation was invalid or timed out |

## Verification
The assertions assume that the frame and bit clocks are slower than the master clock and that their edges are at least a few master clocks apart, so the two-flop synchronisers see every edge. They also assume that master-domain results are at least a few reference cycles apart. The bench derives the frame and bit clocks from a counter on its own master clock. It changes rate, ratio, bit count or duty only at a frame rising edge, so there is never a half-measured frame. It keeps every frame rate at 4 kHz or above except in the deliberate frame-clock-stop case.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5,
    RC_768  = 3'd6
  } ratio_code_e;

  localparam int NUM_RATIOS = 6;

  // strobes sent from the datapath to the control, one cycle wide
  typedef struct packed {
    logic frameDone;  // a full frame measurement is presented
    logic timeout;    // frame clock silent for too long
  } meas_strobe_t;

  typedef struct packed {
    logic        speedDouble;
    logic        div2;
    ratio_code_e code;
  } decision_t;

  // listed ratio i equals baseRatio * ratioHalves(i) / 2
  function automatic int ratioHalves(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/crd_datapath.sv
module crd_datapath
  import crd_pkg::*;
#(
  parameter int MW        = 11,
  parameter int BW        = 8,
  parameter int PW        = 15,
  parameter int P_TIMEOUT = 31250,
  parameter int STAGES    = 2
) (
  input  logic          mclk,
  input  logic          refClk,
  input  logic          rstN,
  input  logic          lrck,
  input  logic          sclk,
  output meas_strobe_t  strobes,
  output logic [MW-1:0] mclkPerFrame,
  output logic [BW-1:0] bitsPerFrame,
  output logic [PW-1:0] refPerFrame
);

  localparam logic [MW-1:0] M_MAX = {MW{1'b1}};
  localparam logic [BW-1:0] B_MAX = {BW{1'b1}};
  localparam logic [PW-1:0] P_TO  = PW'(P_TIMEOUT);
  localparam logic [PW-1:0] P_SAT = PW'(P_TIMEOUT + 1);

  // ---------------- master-clock domain ----------------
  logic          lrckM, sclkM, lrckMd, sclkMd;
  logic          frameRiseM, bitRiseM;
  logic [MW-1:0] mCnt, mLatch, mCntInc;
  logic [BW-1:0] bCnt, bLatch, bCntInc;
  logic          mPrimed, mToggle;

  crd_sync #(.STAGES(STAGES)) uSyncLrckM (.clk(mclk), .rstN(rstN), .d(lrck), .q(lrckM));
  crd_sync #(.STAGES(STAGES)) uSyncSclkM (.clk(mclk), .rstN(rstN), .d(sclk), .q(sclkM));

  assign frameRiseM = lrckM & ~lrckMd;
  assign bitRiseM   = sclkM & ~sclkMd;
  assign mCntInc    = (mCnt == M_MAX) ? M_MAX : mCnt + 1'b1;
  assign bCntInc    = (bitRiseM && bCnt != B_MAX) ? bCnt + 1'b1 : bCnt;

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      lrckMd  <= 1'b0;
      sclkMd  <= 1'b0;
      mCnt    <= '0;
      bCnt    <= '0;
      mLatch  <= '0;
      bLatch  <= '0;
      mPrimed <= 1'b0;
      mToggle <= 1'b0;
    end else begin
      lrckMd <= lrckM;
      sclkMd <= sclkM;
      if (frameRiseM) begin
        mCnt    <= '0;
        bCnt    <= '0;
        mPrimed <= 1'b1;
        if (mPrimed) begin
          mLatch  <= mCntInc;
          bLatch  <= bCntInc;
          mToggle <= ~mToggle;
        end
      end else begin
        mCnt <= mCntInc;
        bCnt <= bCntInc;
      end
    end
  end

  // ---------------- reference-clock domain ----------------
  logic          lrckR, lrckRd, frameRiseR;
  logic          togR, togRd, newMeas;
  logic [PW-1:0] pCnt;
  logic          pPrimed, pValid;
  logic          doneQ, timeoutQ;

  crd_sync #(.STAGES(STAGES)) uSyncLrckR (.clk(refClk), .rstN(rstN), .d(lrck),    .q(lrckR));
  crd_sync #(.STAGES(STAGES)) uSyncTogR  (.clk(refClk), .rstN(rstN), .d(mToggle), .q(togR));

  assign frameRiseR = lrckR & ~lrckRd;
  assign newMeas    = togR ^ togRd;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lrckRd       <= 1'b0;
      togRd        <= 1'b0;
      pCnt         <= '0;
      pPrimed      <= 1'b0;
      pValid       <= 1'b0;
      refPerFrame  <= '0;
      mclkPerFrame <= '0;
      bitsPerFrame <= '0;
      doneQ        <= 1'b0;
      timeoutQ     <= 1'b0;
    end else begin
      lrckRd   <= lrckR;
      togRd    <= togR;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
      if (frameRiseR) begin
        pCnt        <= '0;
        pPrimed     <= 1'b1;
        pValid      <= pPrimed && (pCnt < P_TO);
        refPerFrame <= pCnt + 1'b1;
      end else if (pCnt != P_SAT) begin
        pCnt <= pCnt + 1'b1;
        if (pCnt == P_TO && pPrimed) begin
          pValid   <= 1'b0;
          timeoutQ <= 1'b1;
        end
      end
      // master-domain values are quasi-static for a whole frame
      if (newMeas) begin
        mclkPerFrame <= mLatch;
        bitsPerFrame <= bLatch;
        doneQ        <= pValid;
      end
    end
  end

  assign strobes.frameDone = doneQ;
  assign strobes.timeout   = timeoutQ;

  // R10: the silence strobe is a single pulse per silent stretch
  p_timeout_pulse_r10: assert property (@(posedge refClk) disable iff (!rstN)
    strobes.timeout |=> !strobes.timeout);

  // R7: a frame result is never presented on two cycles in a row
  p_done_pulse_r7: assert property (@(posedge refClk) disable iff (!rstN)
    strobes.frameDone |=> !strobes.frameDone);

endmodule

// File: rtl/crd_ctrl.sv
module crd_ctrl
  import crd_pkg::*;
#(
  parameter int REF_HZ      = 125_000_000,
  parameter int SGL_MIN_HZ  = 4000,
  parameter int SGL_MAX_HZ  = 54000,
  parameter int DBL_MIN_HZ  = 86000,
  parameter int DBL_MAX_HZ  = 108000,
  parameter int BASE_RATIO  = 128,
  parameter int RATIO_TOL   = 2,
  parameter int FULL_BITS   = 64,
  parameter int SHORT_BITS  = 48,
  parameter int LOCK_FRAMES = 3,
  parameter int MW          = 11,
  parameter int BW          = 8,
  parameter int PW          = 15
) (
  input  logic          refClk,
  input  logic          rstN,
  input  meas_strobe_t  strobes,
  input  logic [MW-1:0] mclkPerFrame,
  input  logic [BW-1:0] bitsPerFrame,
  input  logic [PW-1:0] refPerFrame,
  output logic          speedDouble,
  output logic          mclkDiv2,
  output logic [2:0]    ratioCode,
  output logic          locked,
  output logic          clocksBad
);

  localparam int P_SGL_MIN = REF_HZ / SGL_MAX_HZ;
  localparam int P_SGL_MAX = REF_HZ / SGL_MIN_HZ;
  localparam int P_DBL_MIN = REF_HZ / DBL_MAX_HZ;
  localparam int P_DBL_MAX = REF_HZ / DBL_MIN_HZ;
  localparam int CW        = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(LOCK_FRAMES);

  ratio_code_e   matchCode;
  logic          rateSgl, rateDbl, inMode, wideOk, bitsOk, resValid;
  decision_t     curDec, prevDec, outDec;
  logic          prevValid;
  logic [CW-1:0] lockCnt, nextCnt;

  // ---------------- classification of one frame ----------------
  always_comb begin
    matchCode = RC_NONE;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (int'(mclkPerFrame) >= BASE_RATIO * ratioHalves(i) / 2 - RATIO_TOL &&
          int'(mclkPerFrame) <= BASE_RATIO * ratioHalves(i) / 2 + RATIO_TOL)
        matchCode = ratio_code_e'(3'(i + 1));
    end
  end

  assign rateSgl = int'(refPerFrame) >= P_SGL_MIN && int'(refPerFrame) <= P_SGL_MAX;
  assign rateDbl = int'(refPerFrame) >= P_DBL_MIN && int'(refPerFrame) <= P_DBL_MAX;

  always_comb begin
    if (rateDbl)      inMode = matchCode inside {RC_128, RC_192, RC_256, RC_384};
    else if (rateSgl) inMode = matchCode inside {RC_256, RC_384, RC_512, RC_768};
    else              inMode = 1'b0;
  end

  assign wideOk   = matchCode inside {RC_192, RC_384, RC_768};
  assign bitsOk   = (int'(bitsPerFrame) == FULL_BITS) ||
                    (wideOk && int'(bitsPerFrame) == SHORT_BITS);
  assign resValid = inMode && bitsOk;

  always_comb begin
    curDec.speedDouble = rateDbl;
    curDec.code        = matchCode;
    curDec.div2        = rateDbl ? (matchCode inside {RC_256, RC_384})
                                 : (matchCode inside {RC_512, RC_768});
  end

  // ---------------- lock sequencing ----------------
  always_comb begin
    nextCnt = (lockCnt != CNT_FULL) ? lockCnt + 1'b1 : lockCnt;
    if (!(prevValid && curDec == prevDec)) nextCnt = CW'(1);
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      lockCnt   <= '0;
      prevValid <= 1'b0;
      prevDec   <= '0;
      outDec    <= '0;
      locked    <= 1'b0;
      clocksBad <= 1'b0;
    end else if (strobes.timeout) begin
      lockCnt   <= '0;
      prevValid <= 1'b0;
      locked    <= 1'b0;
      clocksBad <= 1'b1;
    end else if (strobes.frameDone) begin
      if (!resValid) begin
        lockCnt   <= '0;
        prevValid <= 1'b0;
        locked    <= 1'b0;
        clocksBad <= 1'b1;
      end else begin
        lockCnt   <= nextCnt;
        prevValid <= 1'b1;
        prevDec   <= curDec;
        clocksBad <= 1'b0;
        locked    <= (nextCnt == CNT_FULL);
        if (nextCnt == CNT_FULL) outDec <= curDec;
      end
    end
  end

  assign speedDouble = outDec.speedDouble;
  assign mclkDiv2    = outDec.div2;
  assign ratioCode   = outDec.code;

  // R9: the lock flag and the invalid flag exclude each other
  p_lock_excl_bad_r9: assert property (@(posedge refClk) disable iff (!rstN)
    !(locked && clocksBad));

  // R7: lock can only rise after a frame evaluation
  p_lock_on_eval_r7: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(locked) |-> $past(strobes.frameDone));

  // R8: outputs and lock hold between evaluations
  p_hold_between_r8: assert property (@(posedge refClk) disable iff (!rstN)
    (!strobes.frameDone && !strobes.timeout) |=>
      ($stable(locked) && $stable(speedDouble) && $stable(mclkDiv2) && $stable(ratioCode)));

  // R2: a locked single-speed setting carries a single-speed ratio
  p_single_pair_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (locked && !speedDouble) |-> (ratioCode inside {3'd3, 3'd4, 3'd5, 3'd6}));

  // R3: a locked double-speed setting carries a double-speed ratio
  p_double_pair_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (locked && speedDouble) |-> (ratioCode inside {3'd1, 3'd2, 3'd3, 3'd4}));

  // R10: a timeout drops the lock and raises the invalid flag
  p_timeout_unlock_r10: assert property (@(posedge refClk) disable iff (!rstN)
    strobes.timeout |=> (!locked && clocksBad));

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int REF_HZ      = 125_000_000,
  parameter int SGL_MIN_HZ  = 4000,
  parameter int SGL_MAX_HZ  = 54000,
  parameter int DBL_MIN_HZ  = 86000,
  parameter int DBL_MAX_HZ  = 108000,
  parameter int BASE_RATIO  = 128,
  parameter int RATIO_TOL   = 2,
  parameter int FULL_BITS   = 64,
  parameter int SHORT_BITS  = 48,
  parameter int LOCK_FRAMES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       refClk,
  input  logic       rstN,
  input  logic       lrck,
  input  logic       sclk,
  output logic       speedDouble,
  output logic       mclkDiv2,
  output logic [2:0] ratioCode,
  output logic       locked,
  output logic       clocksBad
);

  localparam int P_TIMEOUT = REF_HZ / SGL_MIN_HZ;
  localparam int MW        = $clog2(BASE_RATIO * 6 + RATIO_TOL + 1) + 1;
  localparam int BW        = $clog2(FULL_BITS * 2 + 1);
  localparam int PW        = $clog2(P_TIMEOUT + 2);

  meas_strobe_t  strobes;
  logic [MW-1:0] mclkPerFrame;
  logic [BW-1:0] bitsPerFrame;
  logic [PW-1:0] refPerFrame;

  crd_datapath #(
    .MW(MW), .BW(BW), .PW(PW), .P_TIMEOUT(P_TIMEOUT), .STAGES(SYNC_STAGES)
  ) uDatapath (
    .mclk(mclk), .refClk(refClk), .rstN(rstN), .lrck(lrck), .sclk(sclk),
    .strobes(strobes), .mclkPerFrame(mclkPerFrame),
    .bitsPerFrame(bitsPerFrame), .refPerFrame(refPerFrame)
  );

  crd_ctrl #(
    .REF_HZ(REF_HZ), .SGL_MIN_HZ(SGL_MIN_HZ), .SGL_MAX_HZ(SGL_MAX_HZ),
    .DBL_MIN_HZ(DBL_MIN_HZ), .DBL_MAX_HZ(DBL_MAX_HZ), .BASE_RATIO(BASE_RATIO),
    .RATIO_TOL(RATIO_TOL), .FULL_BITS(FULL_BITS), .SHORT_BITS(SHORT_BITS),
    .LOCK_FRAMES(LOCK_FRAMES), .MW(MW), .BW(BW), .PW(PW)
  ) uCtrl (
    .refClk(refClk), .rstN(rstN), .strobes(strobes),
    .mclkPerFrame(mclkPerFrame), .bitsPerFrame(bitsPerFrame), .refPerFrame(refPerFrame),
    .speedDouble(speedDouble), .mclkDiv2(mclkDiv2), .ratioCode(ratioCode),
    .locked(locked), .clocksBad(clocksBad)
  );

endmodule

// File: tb/tb_clk_ratio_detect.sv
`timescale 1ns/1ps
module tb_clk_ratio_detect;

  logic       mclk, refClk, rstN, lrck, sclk;
  logic       speedDouble, mclkDiv2, locked, clocksBad;
  logic [2:0] ratioCode;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  // stimulus configuration
  real mHalf  = 1.0e9 / (256.0 * 52000.0) / 2.0;
  real fsCur  = 52000.0;
  int  curR   = 256;
  int  bitsCur = 64;
  int  hiCnt  = 128;
  bit  frozen = 0;
  int  idx    = 0;

  // last locked decision expected on the outputs
  int  hDbl = 0, hD2 = 0, hCode = 0;

  clk_ratio_detect dut (
    .mclk(mclk), .refClk(refClk), .rstN(rstN), .lrck(lrck), .sclk(sclk),
    .speedDouble(speedDouble), .mclkDiv2(mclkDiv2), .ratioCode(ratioCode),
    .locked(locked), .clocksBad(clocksBad)
  );

  initial refClk = 1'b0;
  always #4 refClk = ~refClk;

  initial mclk = 1'b0;
  always #(mHalf) mclk = ~mclk;

  always @(posedge mclk) begin
    if (!frozen) idx <= (idx >= curR - 1) ? 0 : idx + 1;
  end

  assign lrck = (idx < hiCnt);
  assign sclk = (((idx * 2 * bitsCur) / curR) % 2) == 1;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  task automatic model(input real fs, input int r, input int bits,
                       output bit ok, output int dbl, output int d2, output int code);
    int  rl[6] = '{128, 192, 256, 384, 512, 768};
    int  nominal = 0;
    bit  sgl, dblr, bok;
    sgl  = (fs >= 4000.0) && (fs <= 54000.0);
    dblr = (fs >= 86000.0) && (fs <= 108000.0);
    code = 0;
    for (int i = 0; i < 6; i++) begin
      if (r >= rl[i] - 2 && r <= rl[i] + 2) begin
        code = i + 1;
        nominal = rl[i];
      end
    end
    ok = 0; dbl = 0; d2 = 0;
    if (sgl && (nominal == 256 || nominal == 384 || nominal == 512 || nominal == 768)) begin
      ok = 1; d2 = (nominal >= 512) ? 1 : 0;
    end
    if (dblr && (nominal == 128 || nominal == 192 || nominal == 256 || nominal == 384)) begin
      ok = 1; dbl = 1; d2 = (nominal >= 256) ? 1 : 0;
    end
    if (nominal == 192 || nominal == 384 || nominal == 768) bok = (bits == 48 || bits == 64);
    else bok = (bits == 64);
    ok = ok && bok;
  endtask

  task automatic runCfg(input real fs, input int r, input int bits, input int dutyPct);
    @(posedge lrck);
    fsCur   = fs;
    curR    = r;
    bitsCur = bits;
    hiCnt   = r * dutyPct / 100;
    mHalf   = 1.0e9 / (real'(r) * fs) / 2.0;
  endtask

  task automatic waitFrames(input int n);
    repeat (n) @(posedge lrck);
    repeat (30) @(negedge refClk);
  endtask

  task automatic verify(input string req);
    bit ok; int dbl, d2, code;
    model(fsCur, curR, bitsCur, ok, dbl, d2, code);
    if (ok) begin hDbl = dbl; hD2 = d2; hCode = code; end
    chk({req, " locked"},      int'(locked),      ok ? 1 : 0);
    chk({req, " R9 clocksBad"}, int'(clocksBad),  ok ? 0 : 1);
    chk({req, " speedDouble"}, int'(speedDouble), hDbl);
    chk({req, " mclkDiv2"},    int'(mclkDiv2),    hD2);
    chk({req, " ratioCode"},   int'(ratioCode),   hCode);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rstN = 1'b0;
    repeat (10) @(negedge refClk);
    // R1: reset state
    chk("R1 locked",      int'(locked),      0);
    chk("R1 clocksBad",   int'(clocksBad),   0);
    chk("R1 speedDouble", int'(speedDouble), 0);
    chk("R1 mclkDiv2",    int'(mclkDiv2),    0);
    chk("R1 ratioCode",   int'(ratioCode),   0);
    rstN = 1'b1;

    // R7: first edge only primes, one evaluated frame is not enough
    waitFrames(2);
    chk("R7 no lock after first frame", int'(locked), 0);
    waitFrames(3);
    verify("R2 52k 256x");

    // R8: changed ratio clears lock, relocks after three frames
    runCfg(52000.0, 512, 64, 50);
    waitFrames(2);
    chk("R8 lock cleared on change", int'(locked), 0);
    chk("R8 outputs held at 256x", int'(ratioCode), 3);
    waitFrames(2);
    verify("R2 52k 512x");

    runCfg(52000.0, 384, 48, 50);
    waitFrames(4);
    verify("R6 R2 52k 384x 48 bits");

    runCfg(52000.0, 768, 64, 50);
    waitFrames(2);
    chk("R7 two frames not enough", int'(locked), 0);
    waitFrames(2);
    verify("R2 52k 768x");

    // R4: 256x in double band halves the master clock
    runCfg(96000.0, 256, 64, 50);
    waitFrames(4);
    verify("R4 R3 96k 256x");

    runCfg(96000.0, 128, 64, 50);
    waitFrames(4);
    verify("R3 96k 128x");

    runCfg(96000.0, 192, 48, 50);
    waitFrames(4);
    verify("R3 R6 96k 192x 48 bits");

    // R11: 40 percent duty
    runCfg(96000.0, 384, 64, 40);
    waitFrames(4);
    verify("R11 R3 96k 384x duty 40");

    // R4: rate between bands
    runCfg(70000.0, 256, 64, 50);
    waitFrames(4);
    verify("R4 R8 70k gap");

    // R6: wrong bit count
    runCfg(96000.0, 256, 32, 50);
    waitFrames(4);
    verify("R6 96k 256x 32 bits");

    // R5: tolerance edges and unlisted ratio
    runCfg(96000.0, 258, 64, 50);
    waitFrames(4);
    verify("R5 96k 258x");

    runCfg(96000.0, 259, 64, 50);
    waitFrames(4);
    verify("R5 96k 259x");

    runCfg(96000.0, 320, 64, 50);
    waitFrames(4);
    verify("R5 96k 320x");

    runCfg(52000.0, 384, 64, 60);
    waitFrames(4);
    verify("R11 R2 52k 384x duty 60");

    // R10: frame clock stops
    @(posedge lrck);
    frozen = 1;
    repeat (31400) @(negedge refClk);
    chk("R10 locked after silence",    int'(locked),    0);
    chk("R10 clocksBad after silence", int'(clocksBad), 1);
    chk("R10 R8 ratioCode held",       int'(ratioCode), hCode);

    done = 1;
    finishRun();
  end

  initial begin
    repeat (199000) @(posedge refClk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finishRun();
    end
  end

endmodule